// File: doc/BRIEF.md
# DAC Register File with Persistent Shadow Copy

This block is the register and persistence controller of a digital-to-analog converter. It receives already decoded write commands, one per strobe. Each carries a 3-bit command code, 2 power-down select bits and a 12-bit output code. It holds the live converter register, which drives the analog stage, and a 14-bit non-volatile shadow word. The shadow is modelled as storage that keeps its value through reset and that takes a fixed, parameterised number of cycles to program.

A fast write changes only the live register. A persistence write changes the live register at once and also starts a timed programming sequence for the shadow. While that sequence runs, the ready flag is low and every new write command is dropped. When the block leaves reset, the live register is loaded from the shadow, so a value that was persisted comes back after a reset. The shadow starts out holding the factory word: power-down 00 and a mid-scale code. A 19-bit status word and a separate copy of the shadow can be read at any time.

Top module: `dac_nv_regctl`

## Requirements
- R1: While `rst_n` is low, `rdy` is 1 and `por_flag` (status bit 14) is 0. The live register is loaded from the shadow. `por_flag` reads 1 from the first clock edge after reset is released.
- R2: Before any persistence write completes, the shadow holds the factory word: power-down bits 00 and code 12'h800. After the first reset, the outputs show `dac_pd`=0 and `dac_code`=12'h800.
- R3: A strobed command with code 3'b000 or 3'b010, accepted while `rdy` is 1, sets `dac_pd`/`dac_code` to the command's fields at the next clock edge. `rdy` stays 1 and the shadow does not change.
- R4: A strobed command with code 3'b011, accepted while `rdy` is 1, sets `dac_pd`/`dac_code` at the next edge. At that same edge `rdy` goes to 0, and it stays 0 for exactly WR_LAT cycles.
- R5: The shadow takes the pd/data of the persistence command at the same edge where `rdy` returns to 1, and not before. `shadow_word` is {pd[1:0], data[11:0]}.
- R6: A strobed command that arrives while `rdy` is 0 is dropped, whatever its code. The live register, the shadow and the status command field stay unchanged. A command that arrives in the first cycle after `rdy` returns to 1 is accepted.
- R7: Codes other than 3'b000, 3'b010 and 3'b011 are no-ops. They change neither the outputs nor the status command field.
- R8: `status_word` is {last accepted command code[18:16], rdy[15], por_flag[14], pd[13:12], code[11:0]}. The command field reads 0 after reset.
- R9: A reset during a persistence write aborts the write. The shadow keeps its earlier value and `rdy` returns to 1.
- R10: After a reset, `dac_pd`/`dac_code` equal the last completed shadow contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_vld | input | 1 | One-cycle command strobe |
| cmd_code | input | 3 | Command code |
| cmd_pd | input | 2 | Power-down select bits of the command |
| cmd_data | input | 12 | Output code of the command |
| dac_code | output | 12 | Live converter code |
| dac_pd | output | 2 | Live power-down select |
| rdy | output | 1 | 1 when idle, 0 while the shadow is being programmed |
| status_word | output | 19 | Read-back status word |
| shadow_word | output | 14 | Current shadow contents |

## Verification
The checker watches every cycle for four things: the shadow changes only at the edge where `rdy` rises; each busy period lasts exactly WR_LAT cycles; a strobe during busy leaves the live register and the command field alone; and accepted fast and persistence writes land one edge later. The bench scenarios cover the rest. These include the factory value seen at the first reset, the reload of a persisted value through a later reset, the abort of a write by a reset in mid-program, the no-op codes, and acceptance of a command in the very first ready cycle.

// File: rtl/dac_nv_pkg.sv
// Shared widths, command codes and word types for the DAC register block.
// Assumes a 3-bit command code and a shadow word of power-down over data.
package dac_nv_pkg;
    localparam int CMD_W  = 3;
    localparam int PD_W   = 2;
    localparam int DATA_W = 12;
    localparam int NV_W   = PD_W + DATA_W;
    localparam int STAT_W = CMD_W + 2 + NV_W;

    typedef logic [CMD_W-1:0] cmd_t;

    localparam cmd_t CMD_FAST    = 3'b000;
    localparam cmd_t CMD_DAC     = 3'b010;
    localparam cmd_t CMD_PERSIST = 3'b011;

    typedef struct packed {
        logic [PD_W-1:0]   pd;
        logic [DATA_W-1:0] data;
    } nv_word_t;

    localparam nv_word_t FACTORY_WORD = '{pd: '0, data: DATA_W'(1) << (DATA_W - 1)};
endpackage

// File: rtl/dac_nv_cmd_dec.sv
// Command decoder: turns a strobed command into write enables.
// Assumes ready is low for the whole persistence sequence; drops commands then.
module dac_nv_cmd_dec
    import dac_nv_pkg::*;
(
    input  logic cmd_vld,
    input  cmd_t cmd_code,
    input  logic ready,
    output logic live_we,
    output logic persist_go
);
    // Decode an accepted command into live and shadow enables.
    always_comb begin
        live_we    = 1'b0;
        persist_go = 1'b0;
        if (cmd_vld && ready) begin
            case (cmd_code)
                CMD_FAST, CMD_DAC: live_we = 1'b1;
                CMD_PERSIST: begin
                    live_we    = 1'b1;
                    persist_go = 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dac_nv_shadow.sv
// Shadow store with a timed programming sequence.
// The stored word survives reset and starts out as the factory word.
// A start pulse captures the word; after WR_LAT cycles it is committed and
// ready returns high. Reset aborts a sequence without a commit. WR_LAT >= 1.
module dac_nv_shadow
    import dac_nv_pkg::*;
#(
    parameter int WR_LAT = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     persist_go,
    input  nv_word_t wr_word,
    output nv_word_t nv_word,
    output logic     ready
);
    localparam int CNT_W = $clog2(WR_LAT + 1);

    nv_word_t         nv_q = FACTORY_WORD;
    nv_word_t         pend_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             last_tick;

    assign last_tick = busy_q && (cnt_q == CNT_W'(1));

    // Sequence control: load the counter on start, count down while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (busy_q) begin
            if (last_tick) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end else if (persist_go) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(WR_LAT);
        end
    end

    // Capture the word to be programmed when a sequence starts.
    always_ff @(posedge clk) begin
        if (persist_go && !busy_q) pend_q <= wr_word;
    end

    // Commit the pending word on the final count; reset never clears it.
    always_ff @(posedge clk) begin
        if (rst_n && last_tick) nv_q <= pend_q;
    end

    assign nv_word = nv_q;
    assign ready   = !busy_q;
endmodule

// File: rtl/dac_nv_live.sv
// Live converter register, last-command field and power-on flag.
// Assumes nv_word is stable during reset; it loads the live register then.
module dac_nv_live
    import dac_nv_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     live_we,
    input  cmd_t     cmd_code,
    input  nv_word_t wr_word,
    input  nv_word_t nv_word,
    output nv_word_t live_word,
    output cmd_t     last_cmd,
    output logic     por_flag
);
    nv_word_t live_q;
    cmd_t     cmd_q;
    logic     por_q;

    // Live register: reload from the shadow in reset, else take accepted writes.
    always_ff @(posedge clk) begin
        if (!rst_n)       live_q <= nv_word;
        else if (live_we) live_q <= wr_word;
    end

    // Record the code of the last accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n)       cmd_q <= '0;
        else if (live_we) cmd_q <= cmd_code;
    end

    // Power-on flag: set once the reset-time reload has happened.
    always_ff @(posedge clk) begin
        if (!rst_n) por_q <= 1'b0;
        else        por_q <= 1'b1;
    end

    assign live_word = live_q;
    assign last_cmd  = cmd_q;
    assign por_flag  = por_q;
endmodule

// File: rtl/dac_nv_regctl.sv
// Top: DAC register controller with a persistent shadow word.
// Joins the decoder, the shadow store and the live register, and builds the
// status word. Commands are single-cycle strobes with no back-pressure.
module dac_nv_regctl
    import dac_nv_pkg::*;
#(
    parameter int WR_LAT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_vld,
    input  logic [CMD_W-1:0]  cmd_code,
    input  logic [PD_W-1:0]   cmd_pd,
    input  logic [DATA_W-1:0] cmd_data,
    output logic [DATA_W-1:0] dac_code,
    output logic [PD_W-1:0]   dac_pd,
    output logic              rdy,
    output logic [STAT_W-1:0] status_word,
    output logic [NV_W-1:0]   shadow_word
);
    nv_word_t wr_word;
    nv_word_t nv_word;
    nv_word_t live_word;
    cmd_t     last_cmd;
    logic     live_we;
    logic     persist_go;
    logic     ready;
    logic     por_flag;

    assign wr_word = '{pd: cmd_pd, data: cmd_data};

    dac_nv_cmd_dec u_dec (
        .cmd_vld    (cmd_vld),
        .cmd_code   (cmd_code),
        .ready      (ready),
        .live_we    (live_we),
        .persist_go (persist_go)
    );

    dac_nv_shadow #(.WR_LAT(WR_LAT)) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .persist_go (persist_go),
        .wr_word    (wr_word),
        .nv_word    (nv_word),
        .ready      (ready)
    );

    dac_nv_live u_live (
        .clk       (clk),
        .rst_n     (rst_n),
        .live_we   (live_we),
        .cmd_code  (cmd_code),
        .wr_word   (wr_word),
        .nv_word   (nv_word),
        .live_word (live_word),
        .last_cmd  (last_cmd),
        .por_flag  (por_flag)
    );

    assign dac_code    = live_word.data;
    assign dac_pd      = live_word.pd;
    assign rdy         = ready;
    assign shadow_word = nv_word;
    assign status_word = {last_cmd, ready, por_flag, live_word};
endmodule

// File: rtl/dac_nv_regctl_chk.sv
// Checker for dac_nv_regctl, attached by bind. Watches ports only.
module dac_nv_regctl_chk
    import dac_nv_pkg::*;
#(
    parameter int WR_LAT = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_vld,
    input logic [CMD_W-1:0]  cmd_code,
    input logic [PD_W-1:0]   cmd_pd,
    input logic [DATA_W-1:0] cmd_data,
    input logic [DATA_W-1:0] dac_code,
    input logic [PD_W-1:0]   dac_pd,
    input logic              rdy,
    input logic [STAT_W-1:0] status_word,
    input logic [NV_W-1:0]   shadow_word
);
    int busy_len;

    // Length of the current low period of rdy.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_len <= 0;
        else if (!rdy) busy_len <= busy_len + 1;
        else           busy_len <= 0;
    end

    // R3: fast write lands one edge later
    p_fast_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && rdy && (cmd_code == CMD_DAC || cmd_code == CMD_FAST))
        |=> (dac_code == $past(cmd_data) && dac_pd == $past(cmd_pd) && rdy));

    // R4: persistence write updates live register and drops rdy
    p_persist_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && rdy && cmd_code == CMD_PERSIST)
        |=> (!rdy && dac_code == $past(cmd_data) && dac_pd == $past(cmd_pd)));

    // R4: busy period lasts exactly WR_LAT cycles
    p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy) |-> (busy_len == WR_LAT));

    p_busy_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy |-> (busy_len < WR_LAT));

    // R5: shadow changes only when rdy returns high
    p_shadow_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(shadow_word) |-> $rose(rdy));

    // R6: commands while busy leave live register and command field alone
    p_drop_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && !rdy)
        |=> ($stable(dac_code) && $stable(dac_pd) && $stable(status_word[STAT_W-1 -: CMD_W])));
endmodule

bind dac_nv_regctl dac_nv_regctl_chk #(.WR_LAT(WR_LAT)) u_chk (.*);

// File: tb/dac_nv_regctl_tb_top.sv
// Bench for dac_nv_regctl: a behavioural reference model compared every
// cycle, plus directed scenario checks.
module dac_nv_regctl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_vld = 1'b0;
    logic [2:0]  cmd_code = 3'd0;
    logic [1:0]  cmd_pd = 2'd0;
    logic [11:0] cmd_data = 12'd0;
    logic [11:0] dac_code;
    logic [1:0]  dac_pd;
    logic        rdy;
    logic [18:0] status_word;
    logic [13:0] shadow_word;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // Reference model state
    int m_shadow = 'h800;
    int m_pend = 0;
    int m_live = 0;
    int m_cmd = 0;
    int m_por = 0;
    int m_busy = 0;
    int m_cnt = 0;

    dac_nv_regctl #(.WR_LAT(LAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_code(cmd_code),
        .cmd_pd(cmd_pd), .cmd_data(cmd_data), .dac_code(dac_code),
        .dac_pd(dac_pd), .rdy(rdy), .status_word(status_word),
        .shadow_word(shadow_word)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference model, advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_live = m_shadow;
            m_por = 0; m_busy = 0; m_cnt = 0; m_cmd = 0;
        end else begin
            m_por = 1;
            if (m_busy != 0) begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) begin
                    m_shadow = m_pend;
                    m_busy = 0;
                end
            end else if (cmd_vld) begin
                if (cmd_code == 3'b000 || cmd_code == 3'b010 || cmd_code == 3'b011) begin
                    m_live = {cmd_pd, cmd_data};
                    m_cmd = cmd_code;
                    if (cmd_code == 3'b011) begin
                        m_pend = {cmd_pd, cmd_data};
                        m_busy = 1;
                        m_cnt = LAT;
                    end
                end
            end
        end
    end

    // Compare the outputs with the model away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            chk({dac_pd, dac_code} == m_live[13:0], "R3 model live", {dac_pd, dac_code}, m_live);
            chk(shadow_word == m_shadow[13:0], "R5 model shadow", shadow_word, m_shadow);
            chk(rdy == (m_busy == 0), "R4 model rdy", rdy, m_busy == 0);
            chk(status_word == {m_cmd[2:0], (m_busy == 0), m_por[0], m_live[13:0]},
                "R8 model status", status_word,
                {m_cmd[2:0], (m_busy == 0), m_por[0], m_live[13:0]});
        end
    end

    task automatic send(input logic [2:0] c, input logic [1:0] p, input logic [11:0] d);
        cmd_vld = 1'b1; cmd_code = c; cmd_pd = p; cmd_data = d;
        @(negedge clk);
        cmd_vld = 1'b0;
    endtask

    task automatic reset_for(input int n);
        rst_n = 1'b0;
        repeat (n) @(negedge clk);
        chk(status_word[14] == 1'b0, "R1 por low in reset", status_word[14], 0);
        chk(rdy == 1'b1, "R1 rdy high in reset", rdy, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(status_word[14] == 1'b1, "R1 por set after reset", status_word[14], 1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        @(negedge clk);
        reset_for(3);
        // R2: factory word after first reset
        chk(shadow_word == 14'h0800, "R2 factory shadow", shadow_word, 'h800);
        chk(dac_code == 12'h800 && dac_pd == 2'd0, "R2 factory live", {dac_pd, dac_code}, 'h800);
        chk(status_word[18:16] == 3'd0, "R8 command field after reset", status_word[18:16], 0);

        // R3: fast writes
        send(3'b010, 2'd1, 12'h123);
        chk({dac_pd, dac_code} == 14'h1123, "R3 code 010", {dac_pd, dac_code}, 'h1123);
        chk(rdy && shadow_word == 14'h0800, "R3 no busy no shadow", {rdy, shadow_word}, 'h4800);
        send(3'b000, 2'd2, 12'habc);
        chk({dac_pd, dac_code} == 14'h2abc, "R3 code 000", {dac_pd, dac_code}, 'h2abc);
        chk(status_word == {3'b000, 1'b1, 1'b1, 14'h2abc}, "R8 status layout", status_word,
            {3'b000, 1'b1, 1'b1, 14'h2abc});

        // R7: no-op codes
        send(3'b101, 2'd3, 12'hfff);
        send(3'b111, 2'd1, 12'h001);
        chk({dac_pd, dac_code} == 14'h2abc && status_word[18:16] == 3'b000,
            "R7 no-op codes", status_word, {3'b000, 2'b11, 14'h2abc});

        // R4/R5/R6: persistence write with commands during busy
        send(3'b011, 2'd3, 12'h5a5);
        chk({dac_pd, dac_code} == 14'h35a5, "R4 live updated", {dac_pd, dac_code}, 'h35a5);
        chk(rdy == 1'b0, "R4 rdy low", rdy, 0);
        chk(shadow_word == 14'h0800, "R5 shadow not yet", shadow_word, 'h800);
        n = 0;
        while (rdy == 1'b0 && n < 1000) begin
            cmd_vld = (n >= 1 && n <= 5);
            cmd_code = (n <= 3) ? 3'b010 : 3'b011;
            cmd_pd = 2'd0; cmd_data = 12'h111;
            @(negedge clk);
            n++;
            if (rdy == 1'b0)
                chk(shadow_word == 14'h0800, "R5 shadow held while busy", shadow_word, 'h800);
        end
        cmd_vld = 1'b0;
        chk(n == LAT, "R4 busy length", n, LAT);
        chk(shadow_word == 14'h35a5, "R5 shadow committed", shadow_word, 'h35a5);
        chk({dac_pd, dac_code} == 14'h35a5 && status_word[18:16] == 3'b011,
            "R6 busy commands dropped", status_word, {3'b011, 2'b11, 14'h35a5});
        // R6: first ready cycle accepts
        send(3'b010, 2'd0, 12'h777);
        chk({dac_pd, dac_code} == 14'h0777, "R6 accept at rdy rise", {dac_pd, dac_code}, 'h777);

        // R10: persisted word comes back through reset
        reset_for(2);
        chk({dac_pd, dac_code} == 14'h35a5, "R10 reload from shadow", {dac_pd, dac_code}, 'h35a5);

        // R9: reset in mid-program aborts
        send(3'b011, 2'd1, 12'h0f0);
        repeat (LAT / 2) @(negedge clk);
        chk(rdy == 1'b0, "R9 busy before abort", rdy, 0);
        reset_for(2);
        chk(rdy == 1'b1, "R9 rdy after abort", rdy, 1);
        chk(shadow_word == 14'h35a5, "R9 shadow kept", shadow_word, 'h35a5);
        chk({dac_pd, dac_code} == 14'h35a5, "R9 live reloaded", {dac_pd, dac_code}, 'h35a5);
        repeat (LAT + 2) @(negedge clk);
        chk(shadow_word == 14'h35a5, "R9 no late commit", shadow_word, 'h35a5);

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule